// File: doc/BRIEF.md
# Instruction Phase Sequencer

This block orders the cycles of each instruction in a small core that has no real pipeline: while one word executes, the next address is formed and the next word is read from instruction memory. Most instructions take a single execute cycle. A constant load from instruction memory needs one more read cycle. An instruction that writes the program counter, other than the two that load it directly (the SET/CALL class), needs one more cycle to fetch from the new address instead of the incremented one.

The execution controller supplies a permission level (high while the core is running or stepping) and a pulse on each new command. The decoder supplies a two-bit opcode class and a flag that says the destination is the program counter. The block drives the current phase, a one-cycle completion pulse on the last cycle of each instruction, and a trap flag. An invalid opcode is never executed: it parks the sequencer in the idle phase until a new command arrives.

Top module: `instr_phase_seq`

## Requirements
- R1: While rst_n is low and on the first cycle after it rises, phase is 0 (idle), trapped is 0 and instr_done is 0.
- R2: If go is low at a clock edge, phase is 0 (idle) in the following cycle, from any phase.
- R3: From idle, with go high and trapped low at a clock edge, phase is 1 (execute) in the following cycle.
- R4: An instruction of class 0 (ordinary) with dst_pc low, or of class 2 (SET/CALL) with any dst_pc, completes in one cycle: instr_done is high in its execute cycle and the next cycle is execute again.
- R5: A class 1 (constant load) instruction with dst_pc low takes two cycles: execute, then phase 2 (constant read), with instr_done high only in the second.
- R6: A class 0 instruction with dst_pc high takes two cycles: execute, then phase 3 (new-address fetch), with instr_done high only in the second.
- R7: A class 1 instruction with dst_pc high takes three cycles: execute, constant read, new-address fetch, with instr_done high only in the third.
- R8: A class 3 (invalid) instruction in the execute phase does not complete: instr_done stays low, and the next cycle has phase 0 and trapped 1.
- R9: While trapped is 1 and cmd_new is low, phase stays 0 even with go high; a cmd_new pulse clears trapped and, with go high, phase is 1 in the following cycle.
- R10: instr_done is high at most once per instruction and never outside the execute, constant read or new-address fetch phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Run or step permission from the execution controller |
| cmd_new | input | 1 | One-cycle pulse when a new command is latched |
| op_class | input | 2 | 0 ordinary, 1 constant load, 2 SET/CALL, 3 invalid |
| dst_pc | input | 1 | Destination operand is the program counter |
| phase | output | 2 | 0 idle, 1 execute, 2 constant read, 3 new-address fetch |
| instr_done | output | 1 | Last cycle of the current instruction |
| trapped | output | 1 | Invalid opcode seen, waiting for a new command |

## Verification
On every cycle the assertions check the drop to idle when permission is withdrawn, the entry into the constant read phase, the exemption of the SET/CALL class from the fetch penalty, the return from the fetch phase, the hold of the trap and the absence of a completion pulse for an invalid opcode. The instruction lengths of one, two, two and three cycles, the release of the trap by a new command and the restart latency after a pause are shown only by the bench's scenarios, which count completion pulses per instruction.

// File: rtl/instr_phase_seq.sv
module instr_phase_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       cmd_new,
  input  logic [1:0] op_class,
  input  logic       dst_pc,
  output logic [1:0] phase,
  output logic       instr_done,
  output logic       trapped
);

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_EXEC  = 2'd1,
    PH_CONST = 2'd2,
    PH_FETCH = 2'd3
  } phase_t;

  localparam logic [1:0] CLS_PLAIN = 2'd0;
  localparam logic [1:0] CLS_CONST = 2'd1;
  localparam logic [1:0] CLS_DIRPC = 2'd2;
  localparam logic [1:0] CLS_BAD   = 2'd3;

  phase_t state, state_nx;
  logic   trap_q, trap_nx;

  wire is_const = (op_class == CLS_CONST);
  wire is_bad   = (op_class == CLS_BAD);
  wire pc_pen   = dst_pc && (op_class == CLS_PLAIN);

  always_comb begin
    state_nx = state;
    trap_nx  = trap_q && !cmd_new;
    if (!go) begin
      state_nx = PH_IDLE;
    end else begin
      case (state)
        PH_IDLE:  if (!trap_q || cmd_new) state_nx = PH_EXEC;
        PH_EXEC: begin
          if (is_bad) begin
            state_nx = PH_IDLE;
            trap_nx  = 1'b1;
          end else if (is_const) state_nx = PH_CONST;
          else if (pc_pen)       state_nx = PH_FETCH;
          else                   state_nx = PH_EXEC;
        end
        PH_CONST: state_nx = dst_pc ? PH_FETCH : PH_EXEC;
        PH_FETCH: state_nx = PH_EXEC;
        default:  state_nx = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= PH_IDLE;
      trap_q <= 1'b0;
    end else begin
      state  <= state_nx;
      trap_q <= trap_nx;
    end
  end

  assign phase   = state;
  assign trapped = trap_q;
  assign instr_done = ((state == PH_EXEC) && !is_bad && !is_const && !pc_pen) ||
                      ((state == PH_CONST) && !dst_pc) ||
                      (state == PH_FETCH);

  AST_IDLE_ON_NOGO: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> phase == PH_IDLE); // R2
  AST_CONST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC && go && op_class == CLS_CONST) |=> phase == PH_CONST); // R5
  AST_DIRPC_NO_PENALTY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC && go && op_class == CLS_DIRPC) |=> phase == PH_EXEC); // R4
  AST_FETCH_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FETCH && go) |=> phase == PH_EXEC); // R6
  AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (trapped && !cmd_new) |=> (phase == PH_IDLE && trapped)); // R9
  AST_BAD_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC && op_class == CLS_BAD) |-> !instr_done); // R8
  AST_DONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |-> phase != PH_IDLE); // R10

endmodule

// File: tb/tb_instr_phase_seq.sv
module tb_instr_phase_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic cmd_new = 1'b0;
  logic [1:0] op_class = 2'd0;
  logic dst_pc = 1'b0;
  logic [1:0] phase;
  logic instr_done, trapped;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  instr_phase_seq dut (
    .clk(clk), .rst_n(rst_n), .go(go), .cmd_new(cmd_new),
    .op_class(op_class), .dst_pc(dst_pc),
    .phase(phase), .instr_done(instr_done), .trapped(trapped)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_instr(input logic [1:0] cls, input logic pc, input int exp_len,
                           input string tag);
    int len = 0;
    int dones = 0;
    check(phase, 1, {tag, " start in execute"});
    for (int i = 0; i < 6; i++) begin
      op_class = cls;
      dst_pc = pc;
      #1;
      len++;
      if (instr_done) begin
        dones++;
        break;
      end
      @(negedge clk);
    end
    check(len, exp_len, {tag, " length"});
    check(dones, 1, {tag, " R10 single done"});
    @(negedge clk);
    op_class = 2'd0;
    dst_pc = 1'b0;
    check(phase, 1, {tag, " back to execute"});
  endtask

  task automatic t_reset();
    #1;
    check(phase, 0, "R1 phase in reset");
    check(trapped, 0, "R1 trapped in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(phase, 0, "R1 phase after reset");
    check(instr_done, 0, "R1 done after reset");
  endtask

  task automatic t_start();
    go = 1'b1;
    @(negedge clk);
    check(phase, 1, "R3 idle to execute");
  endtask

  task automatic t_lengths();
    run_instr(2'd0, 1'b0, 1, "R4 ordinary");
    run_instr(2'd2, 1'b1, 1, "R4 setcall to pc");
    run_instr(2'd2, 1'b0, 1, "R4 setcall");
    run_instr(2'd1, 1'b0, 2, "R5 const load");
    run_instr(2'd0, 1'b1, 2, "R6 pc write");
    run_instr(2'd1, 1'b1, 3, "R7 const load to pc");
  endtask

  task automatic t_pause();
    op_class = 2'd1;
    dst_pc = 1'b0;
    @(negedge clk);
    check(phase, 2, "R5 constant read phase");
    go = 1'b0;
    @(negedge clk);
    check(phase, 0, "R2 drop to idle");
    op_class = 2'd0;
    @(negedge clk);
    check(phase, 0, "R2 stays idle");
    go = 1'b1;
    @(negedge clk);
    check(phase, 1, "R3 restart");
  endtask

  task automatic t_trap();
    op_class = 2'd3;
    #1;
    check(instr_done, 0, "R8 no done on invalid");
    @(negedge clk);
    op_class = 2'd0;
    check(phase, 0, "R8 idle after invalid");
    check(trapped, 1, "R8 trapped set");
    for (int i = 0; i < 3; i++) @(negedge clk);
    check(phase, 0, "R9 held idle");
    check(trapped, 1, "R9 still trapped");
    cmd_new = 1'b1;
    @(negedge clk);
    cmd_new = 1'b0;
    check(phase, 1, "R9 released to execute");
    check(trapped, 0, "R9 trap cleared");
    run_instr(2'd0, 1'b0, 1, "R9 ordinary after release");
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_start();
    t_lengths();
    t_pause();
    t_trap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule